// File: doc/BRIEF.md
# ADC Result Word Formatter

This block turns the raw code that a successive-approximation converter delivers into the 16-bit word that a read of a result register returns. The converter may run at 8, 10 or 12 bits. The block offers two output views. The first is an unsigned value packed against bit 0 with zeros above it. The second is a signed two's complement value packed against bit 15 with zeros below it.

The raw code always arrives as an unsigned offset-binary number of the selected width, in the low bits of `raw_code`. This holds for single-ended and for differential conversions. A differential result is first seen as signed: its MSB is inverted. For the unsigned view, the mid-scale offset is then added back. For the signed view, the value is shifted to the top of the word. Since inverting the MSB and adding half-scale cancel, the differential flag never changes the output word.

The shaped word is captured into an output register only on a write strobe, so it can drive the write port of a result memory directly.

Top module: `adc_result_fmt`

## Requirements
- R1: While `rst_n` is low, `result` is 0000h.
- R2: On a rising clock edge with `wr_en` low, `result` keeps its value whatever the other inputs do.
- R3: On a rising clock edge with `wr_en` high, `result` takes the shaped value of the inputs present at that edge, and shows it from that edge on.
- R4: `res_sel` 00 selects 8 bits, 01 selects 10 bits and 10 selects 12 bits. The code is `raw_code[W-1:0]` for a width W, and the bits of `raw_code` at W and above have no effect.
- R5: With `fmt_lj` = 0, `result` is the code zero-extended to 16 bits, so bits 15 down to W are zero.
- R6: With `fmt_lj` = 1, `result` is the code with its MSB inverted, shifted left by 16−W, with zeros in the low 16−W bits. A code of 0 gives 8000h. An all-ones code gives 7F00h, 7FC0h or 7FF0h at 8, 10 or 12 bits.
- R7: `res_sel` = 11 gives exactly the result of `res_sel` = 10 (12 bits).
- R8: `diff_mode` has no effect on `result` in either format.
- R9: With `fmt_lj` = 0, an all-ones code gives 00FFh, 03FFh or 0FFFh at 8, 10 or 12 bits, and a zero code gives 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; loads the output register |
| raw_code | input | 12 | Raw offset-binary converter code, right aligned |
| res_sel | input | 2 | Resolution select: 00 = 8, 01 = 10, 10/11 = 12 bits |
| diff_mode | input | 1 | Conversion was differential |
| fmt_lj | input | 1 | 0 = right-justified unsigned, 1 = left-justified two's complement |
| result | output | 16 | Registered result word |

## Verification
A shaped word is due one clock edge after the strobe that captures it. Between strobes, the word must stay unchanged at every later edge. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares on the next falling edge. It compares against the last captured expectation when the strobe was low. The checker uses the same one-edge relation with `|=>`, so both observe `result` only where the register has settled.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    RES_NARROW = 2'b00,
    RES_MID    = 2'b01,
    RES_WIDE   = 2'b10,
    RES_SPARE  = 2'b11
  } res_sel_e;

  // Width of resolution variant idx when the widest variant is raw_w bits
  function automatic int variant_width(int idx, int num_res, int raw_w, int step);
    return raw_w - step * (num_res - 1 - idx);
  endfunction

endpackage

// File: rtl/adc_fmt_res_decode.sv
module adc_fmt_res_decode
  import adc_fmt_pkg::*;
#(
  parameter int NUM_RES = 3
) (
  input  logic [SEL_W-1:0]   res_sel,
  output logic [NUM_RES-1:0] sel_oh
);

  // Codes beyond the last variant fold onto the widest one
  always_comb begin
    sel_oh = '0;
    for (int i = 0; i < NUM_RES; i++) begin
      if (int'(res_sel) == i) sel_oh[i] = 1'b1;
    end
    if (int'(res_sel) >= NUM_RES) sel_oh[NUM_RES-1] = 1'b1;
  end

endmodule

// File: rtl/adc_fmt_shaper.sv
module adc_fmt_shaper
  import adc_fmt_pkg::*;
#(
  parameter int RAW_W    = 12,
  parameter int OUT_W    = 16,
  parameter int NUM_RES  = 3,
  parameter int RES_STEP = 2
) (
  input  logic [RAW_W-1:0]   raw_code,
  input  logic [NUM_RES-1:0] sel_oh,
  input  logic               diff_mode,
  input  logic               fmt_lj,
  output logic [OUT_W-1:0]   shaped
);

  logic [OUT_W-1:0] cand_rj [NUM_RES];
  logic [OUT_W-1:0] cand_lj [NUM_RES];

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    localparam int W   = variant_width(g, NUM_RES, RAW_W, RES_STEP);
    localparam int PAD = OUT_W - W;
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] code;
    logic [W-1:0] twos;
    logic [W-1:0] rebased;
    logic [W-1:0] unsigned_code;

    assign code    = raw_code[W-1:0];
    // signed view of the offset-binary code
    assign twos    = {~code[W-1], code[W-2:0]};
    // differential path: return to unsigned by adding half scale
    assign rebased = twos + HALF;
    assign unsigned_code = diff_mode ? rebased : code;

    assign cand_rj[g] = {{PAD{1'b0}}, unsigned_code};
    assign cand_lj[g] = {twos, {PAD{1'b0}}};
  end

  always_comb begin
    shaped = '0;
    for (int i = 0; i < NUM_RES; i++) begin
      if (sel_oh[i]) shaped = shaped | (fmt_lj ? cand_lj[i] : cand_rj[i]);
    end
  end

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int RAW_W    = 12,
  parameter int OUT_W    = 16,
  parameter int NUM_RES  = 3,
  parameter int RES_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RAW_W-1:0] raw_code,
  input  logic [SEL_W-1:0] res_sel,
  input  logic             diff_mode,
  input  logic             fmt_lj,
  output logic [OUT_W-1:0] result
);

  logic [NUM_RES-1:0] sel_oh;
  logic [OUT_W-1:0]   shaped;
  logic [OUT_W-1:0]   result_d;
  logic [OUT_W-1:0]   result_q;

  adc_fmt_res_decode #(
    .NUM_RES (NUM_RES)
  ) u_decode (
    .res_sel (res_sel),
    .sel_oh  (sel_oh)
  );

  adc_fmt_shaper #(
    .RAW_W    (RAW_W),
    .OUT_W    (OUT_W),
    .NUM_RES  (NUM_RES),
    .RES_STEP (RES_STEP)
  ) u_shaper (
    .raw_code  (raw_code),
    .sel_oh    (sel_oh),
    .diff_mode (diff_mode),
    .fmt_lj    (fmt_lj),
    .shaped    (shaped)
  );

  always_comb begin
    result_d = result_q;
    if (wr_en) result_d = shaped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= result_d;
  end

  assign result = result_q;

endmodule

// File: rtl/adc_result_fmt_chk.sv
module adc_result_fmt_chk
  import adc_fmt_pkg::*;
#(
  parameter int RAW_W    = 12,
  parameter int OUT_W    = 16,
  parameter int NUM_RES  = 3,
  parameter int RES_STEP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [RAW_W-1:0] raw_code,
  input logic [SEL_W-1:0] res_sel,
  input logic             fmt_lj,
  input logic [OUT_W-1:0] result
);

  localparam int NARROW_W = variant_width(0, NUM_RES, RAW_W, RES_STEP);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (result == '0);
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(result));

  assert_rj_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fmt_lj && res_sel == RES_NARROW) |=> ((result >> NARROW_W) == '0));

  assert_lj_lower_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt_lj) |=> (result[OUT_W-RAW_W-1:0] == '0));

  assert_spare_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt_lj && res_sel == RES_SPARE)
      |=> (result[OUT_W-1] != $past(raw_code[RAW_W-1])));

endmodule

bind adc_result_fmt adc_result_fmt_chk #(
  .RAW_W    (RAW_W),
  .OUT_W    (OUT_W),
  .NUM_RES  (NUM_RES),
  .RES_STEP (RES_STEP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .raw_code (raw_code),
  .res_sel  (res_sel),
  .fmt_lj   (fmt_lj),
  .result   (result)
);

// File: tb/adc_result_fmt_tb.sv
`timescale 1ns/1ps
module adc_result_fmt_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] raw_code;
  logic [1:0]  res_sel;
  logic        diff_mode;
  logic        fmt_lj;
  logic [15:0] result;

  int checks;
  int fails;
  logic [15:0] model_q;

  adc_result_fmt u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .raw_code  (raw_code),
    .res_sel   (res_sel),
    .diff_mode (diff_mode),
    .fmt_lj    (fmt_lj),
    .result    (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] golden(logic [11:0] raw, logic [1:0] res, logic lj);
    int w;
    logic [15:0] code;
    w = (res == 2'b11) ? 12 : 8 + 2 * int'(res);
    code = 16'(raw) & 16'((1 << w) - 1);
    if (!lj) return code;
    code = code ^ 16'(1 << (w - 1));
    return 16'(code << (16 - w));
  endfunction

  task automatic check(string req, logic [15:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s: result=%04h expected=%04h", req, result, exp);
    end
  endtask

  // drive on falling edge, one rising edge, compare on next falling edge
  task automatic apply(logic we, logic [11:0] raw, logic [1:0] res,
                       logic dif, logic lj, string req);
    @(negedge clk);
    wr_en = we; raw_code = raw; res_sel = res; diff_mode = dif; fmt_lj = lj;
    if (we) model_q = golden(raw, res, lj);
    @(negedge clk);
    wr_en = 1'b0;
    check(req, model_q);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: result=%04h expected=done", result);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; fails = 0; model_q = '0;
    rst_n = 1'b0; wr_en = 1'b0; raw_code = 12'hABC; res_sel = 2'b10;
    diff_mode = 1'b0; fmt_lj = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    rst_n = 1'b1;

    // R9 right-justified full scale
    apply(1, 12'h0FF, 2'b00, 0, 0, "R9"); check("R9", 16'h00FF);
    apply(1, 12'h3FF, 2'b01, 0, 0, "R9");
    apply(1, 12'hFFF, 2'b10, 0, 0, "R9"); check("R9", 16'h0FFF);
    apply(1, 12'h000, 2'b10, 1, 0, "R9");
    // R6 left-justified full scale
    apply(1, 12'h000, 2'b00, 0, 1, "R6"); check("R6", 16'h8000);
    apply(1, 12'h0FF, 2'b00, 1, 1, "R6"); check("R6", 16'h7F00);
    apply(1, 12'h3FF, 2'b01, 0, 1, "R6"); check("R6", 16'h7FC0);
    apply(1, 12'hFFF, 2'b10, 1, 1, "R6"); check("R6", 16'h7FF0);
    apply(1, 12'h800, 2'b10, 0, 1, "R6"); check("R6", 16'h0000);
    // R4 upper raw bits ignored
    apply(1, 12'hF5A, 2'b00, 0, 0, "R4"); check("R4", 16'h005A);
    apply(1, 12'hC01, 2'b01, 0, 1, "R4"); check("R4", 16'h8040);
    // R5 mid-range right-justified
    apply(1, 12'h2A5, 2'b01, 0, 0, "R5"); check("R5", 16'h02A5);
    // R7 spare code as 12 bits
    apply(1, 12'h123, 2'b11, 0, 1, "R7"); check("R7", 16'h9230);
    apply(1, 12'hABC, 2'b11, 1, 0, "R7"); check("R7", 16'h0ABC);
    // R8 differential flag changes nothing
    apply(1, 12'h17F, 2'b00, 1, 0, "R8"); check("R8", 16'h007F);
    apply(1, 12'h17F, 2'b00, 1, 1, "R8"); check("R8", 16'hFF00);
    // R2 hold with strobe low
    apply(0, 12'h555, 2'b01, 1, 0, "R2"); check("R2", 16'hFF00);

    for (int i = 0; i < 400; i++) begin
      logic we;
      logic [1:0] res;
      logic lj;
      we  = ($urandom % 4) != 0;
      res = 2'($urandom);
      lj  = 1'($urandom);
      apply(we, 12'($urandom), res, 1'($urandom), lj,
            !we ? "R2" : (res == 2'b11) ? "R7" : lj ? "R6" : "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule